// File: doc/BRIEF.md
# Host Receive Endpoint Control and Status

This block holds the 8-bit control and status byte of one receive endpoint in a host-mode USB controller, together with the state that byte governs: a data-toggle bit, an IN-request flag, a stall flag, two error flags and a small packet queue with ready and full indications. Software writes and reads the byte through a plain register port. The packet engine reports accepted packets, received STALL handshakes and receive errors. It reads back the IN-request and toggle state to decide what to send next.

The queue holds `NBUF` packet descriptors, two by default (double buffering). Software retires the oldest packet in one of two ways. It can write 0 to the packet-ready bit, which is the normal unload. It can also write 1 to the flush bit, which discards the packet. Each action removes exactly one packet, so a full double buffer needs two actions to empty it. An interrupt pulse tells the controller that a stall was seen or that a packet arrived.

Byte layout, from bit 7 down to bit 0: toggle-clear, stalled, IN-request, flush, NAK timeout / data error, error, queue full, packet ready.

Top module: `rxep_ctrl`

## Requirements
- R1: After reset `sw_rdata` is 0x00, and `eng_toggle`, `eng_req_pkt` and `irq` are all 0.
- R2: Writing 1 to bit 7 clears the toggle at that edge, and this takes priority over a flip in the same cycle. Bit 7 always reads 0.
- R3: An `eng_stall` pulse sets bit 6 on the next cycle. Writing 1 to bit 6 does not set it. Only a write with bit 6 at 0 clears it, and a stall in the same cycle wins.
- R4: A write loads bit 5 from the written data, and `eng_req_pkt` mirrors bit 5. Hardware clears bit 5 at the edge where a packet is accepted.
- R5: `eng_pkt_valid` is accepted only when the queue is not full. Bit 0 reads 1 while at least one packet is held. Bit 1 reads 1 while `NBUF` packets are held. A packet offered while the queue is full is dropped.
- R6: Writing 1 to bit 4 while bit 0 is 1 discards the oldest packet. Bit 4 then reads 1 for exactly one cycle. While bit 0 is 0, a flush write changes nothing and bit 4 stays 0.
- R7: With two packets held, one flush leaves bit 0 at 1 and bit 1 at 0, and `head_len` shows the second packet. A second flush empties the queue.
- R8: The toggle inverts at each accepted packet. Dropped packets leave it unchanged.
- R9: Pulses on `eng_nak_to` and `eng_err` set bits 3 and 2. Writing 0 to those bits clears them. Writing 1 to them does not set them.
- R10: Bit 1 is read-only, and writing 1 to it has no effect.
- R11: Writing 0 to bit 0 while it is 1 releases the oldest packet. Writing 1 to bit 0 has no effect. One write removes at most one packet.
- R12: `irq` is high for one cycle, on the cycle after a stall pulse or after an accepted packet.
- R13: `head_len` shows the length of the oldest held packet, and packets leave in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Current register view |
| eng_pkt_valid | input | 1 | Error-free packet received (one-cycle pulse) |
| eng_pkt_len | input | LW | Length of the received packet |
| eng_stall | input | 1 | STALL handshake received (pulse) |
| eng_nak_to | input | 1 | NAK timeout / data error (pulse) |
| eng_err | input | 1 | Receive error (pulse) |
| eng_req_pkt | output | 1 | IN transaction requested |
| eng_toggle | output | 1 | Expected data toggle |
| head_len | output | LW | Length of the oldest held packet |
| irq | output | 1 | Endpoint interrupt pulse |

## Verification
The bench builds the block with `NBUF` = 2 and `LW` = 4, which makes the full double buffer, the overflow drop and the partial flush easy to reach. It sweeps every combination of zero to three offered packets with zero to three flushes. For each combination it computes the held count, the remaining count, the toggle parity and the expected head length arithmetically. Directed sequences then cover the write-one-ignored and write-zero-clear bits, the stall and error flags, the request auto-clear and the interrupt pulse.

// File: rtl/rxep_pkg.sv
package rxep_pkg;
  localparam int unsigned BIT_TOGCLR = 7;
  localparam int unsigned BIT_STALL  = 6;
  localparam int unsigned BIT_REQ    = 5;
  localparam int unsigned BIT_FLUSH  = 4;
  localparam int unsigned BIT_NAKTO  = 3;
  localparam int unsigned BIT_ERR    = 2;
  localparam int unsigned BIT_FULL   = 1;
  localparam int unsigned BIT_READY  = 0;

  // circular pointer advance
  function automatic int unsigned ptr_next(input int unsigned p, input int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // queue occupancy after one cycle
  function automatic int unsigned occ_next(input int unsigned occ, input logic push, input logic pop);
    return occ + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

  // retire condition for one software write
  function automatic logic retire_on_write(input logic [7:0] d, input logic ready);
    return ready & (d[BIT_FLUSH] | ~d[BIT_READY]);
  endfunction
endpackage

// File: rtl/rxep_pktq.sv
module rxep_pktq #(
  parameter int unsigned NBUF = 2,
  parameter int unsigned LW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [LW-1:0] push_len,
  input  logic          pop,
  output logic          ready,
  output logic          full,
  output logic [LW-1:0] head_len
);
  import rxep_pkg::*;
  localparam int unsigned PW = (NBUF > 1) ? $clog2(NBUF) : 1;
  localparam int unsigned CW = $clog2(NBUF + 1);

  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ;
  logic [LW-1:0] slot [NBUF];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= PW'(ptr_next(int'(wr_ptr), NBUF));
      if (pop)  rd_ptr <= PW'(ptr_next(int'(rd_ptr), NBUF));
      occ <= CW'(occ_next(int'(occ), push, pop));
    end
  end

  for (genvar i = 0; i < NBUF; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && wr_ptr == PW'(i)) slot[i] <= push_len;
    end
  end

  assign ready    = (occ != '0);
  assign full     = (occ == CW'(NBUF));
  assign head_len = ready ? slot[rd_ptr] : '0;
endmodule

// File: rtl/rxep_csr.sv
module rxep_csr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_wr,
  input  logic [7:0] sw_wdata,
  input  logic       eng_stall,
  input  logic       eng_nak_to,
  input  logic       eng_err,
  input  logic       accept,
  input  logic       ready,
  input  logic       full,
  output logic       pop,
  output logic [7:0] sw_rdata,
  output logic       req,
  output logic       toggle,
  output logic       irq
);
  import rxep_pkg::*;
  logic stalled_q, req_q, flush_q, nak_q, err_q, tog_q, irq_q;
  logic tog_clr;

  assign tog_clr = sw_wr & sw_wdata[BIT_TOGCLR];
  assign pop     = sw_wr & retire_on_write(sw_wdata, ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stalled_q <= 1'b0;
      req_q     <= 1'b0;
      flush_q   <= 1'b0;
      nak_q     <= 1'b0;
      err_q     <= 1'b0;
      tog_q     <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (eng_stall) stalled_q <= 1'b1;
      else if (sw_wr && !sw_wdata[BIT_STALL]) stalled_q <= 1'b0;

      if (accept) req_q <= 1'b0;
      else if (sw_wr) req_q <= sw_wdata[BIT_REQ];

      flush_q <= sw_wr & sw_wdata[BIT_FLUSH] & ready;

      if (eng_nak_to) nak_q <= 1'b1;
      else if (sw_wr && !sw_wdata[BIT_NAKTO]) nak_q <= 1'b0;

      if (eng_err) err_q <= 1'b1;
      else if (sw_wr && !sw_wdata[BIT_ERR]) err_q <= 1'b0;

      if (tog_clr) tog_q <= 1'b0;
      else if (accept) tog_q <= ~tog_q;

      irq_q <= eng_stall | accept;
    end
  end

  assign sw_rdata = {1'b0, stalled_q, req_q, flush_q, nak_q, err_q, full, ready};
  assign req      = req_q;
  assign toggle   = tog_q;
  assign irq      = irq_q;
endmodule

// File: rtl/rxep_ctrl.sv
module rxep_ctrl #(
  parameter int unsigned NBUF = 2,
  parameter int unsigned LW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_wr,
  input  logic [7:0]    sw_wdata,
  output logic [7:0]    sw_rdata,
  input  logic          eng_pkt_valid,
  input  logic [LW-1:0] eng_pkt_len,
  input  logic          eng_stall,
  input  logic          eng_nak_to,
  input  logic          eng_err,
  output logic          eng_req_pkt,
  output logic          eng_toggle,
  output logic [LW-1:0] head_len,
  output logic          irq
);
  logic accept, pop, ready, full;

  assign accept = eng_pkt_valid & ~full;

  rxep_pktq #(.NBUF(NBUF), .LW(LW)) u_q (
    .clk(clk), .rst_n(rst_n), .push(accept), .push_len(eng_pkt_len),
    .pop(pop), .ready(ready), .full(full), .head_len(head_len)
  );

  rxep_csr u_csr (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .eng_stall(eng_stall), .eng_nak_to(eng_nak_to), .eng_err(eng_err),
    .accept(accept), .ready(ready), .full(full), .pop(pop),
    .sw_rdata(sw_rdata), .req(eng_req_pkt), .toggle(eng_toggle), .irq(irq)
  );
endmodule

// File: rtl/rxep_ctrl_chk.sv
module rxep_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_wr,
  input logic [7:0] sw_wdata,
  input logic [7:0] sw_rdata,
  input logic       eng_pkt_valid,
  input logic       eng_stall,
  input logic       eng_req_pkt,
  input logic       eng_toggle,
  input logic       irq,
  input logic       accept,
  input logic       pop
);
  a_r2_bit7_reads_zero: assert property (@(posedge clk) disable iff (!rst_n) !sw_rdata[7]);
  a_r2_toggle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_wdata[7]) |=> !eng_toggle);
  a_r3_stall_sets: assert property (@(posedge clk) disable iff (!rst_n)
    eng_stall |=> (sw_rdata[6] && irq));
  a_r4_req_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !eng_req_pkt);
  a_r5_full_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rdata[1] |-> sw_rdata[0]);
  a_r5_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_pkt_valid && sw_rdata[1]) |-> !accept);
  a_r6_flush_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rdata[4] |-> $past(sw_wr && sw_wdata[4] && sw_rdata[0]));
  a_r6_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_wdata[4] && !sw_rdata[0] && !eng_pkt_valid) |=> (!sw_rdata[0] && !sw_rdata[4]));
  a_r8_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(sw_wr && sw_wdata[7])) |=> (eng_toggle != $past(eng_toggle)));
  a_r11_pop_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> sw_rdata[0]);
endmodule

bind rxep_ctrl rxep_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
  .eng_pkt_valid(eng_pkt_valid), .eng_stall(eng_stall), .eng_req_pkt(eng_req_pkt),
  .eng_toggle(eng_toggle), .irq(irq), .accept(accept), .pop(pop)
);

// File: tb/rxep_ctrl_bench.sv
module rxep_ctrl_bench;
  localparam int unsigned LW = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_wr = 1'b0;
  logic [7:0] sw_wdata = '0;
  logic [7:0] sw_rdata;
  logic eng_pkt_valid = 1'b0, eng_stall = 1'b0, eng_nak_to = 1'b0, eng_err = 1'b0;
  logic [LW-1:0] eng_pkt_len = '0, head_len;
  logic eng_req_pkt, eng_toggle, irq;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rxep_ctrl #(.NBUF(2), .LW(LW)) u_rxep_ctrl (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic sw_write(input logic [7:0] d);
    @(negedge clk); sw_wr = 1'b1; sw_wdata = d;
    @(negedge clk); sw_wr = 1'b0;
  endtask

  task automatic offer(input logic [LW-1:0] len);
    @(negedge clk); eng_pkt_valid = 1'b1; eng_pkt_len = len;
    @(negedge clk); eng_pkt_valid = 1'b0;
  endtask

  function automatic int len_of(input int k, input int i);
    return (k * 4 + i + 1) % 16;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata", sw_rdata, 8'h00);
    check("R1 toggle/req/irq", {eng_toggle, eng_req_pkt, irq}, 0);

    // R2 R9 R10 R3: write all ones to empty endpoint -> only request set
    sw_write(8'hFF);
    check("R2 R3 R9 R10 write-ones", sw_rdata, 8'h20);
    check("R4 req mirror", eng_req_pkt, 1);
    offer(4'h7);
    check("R4 req autoclear", sw_rdata[5], 0);
    check("R12 irq after packet", irq, 1);
    check("R8 toggle after one", eng_toggle, 1);
    @(negedge clk);
    check("R12 irq one cycle", irq, 0);
    sw_write(8'h81); // clear toggle, keep packet
    check("R2 toggle cleared", eng_toggle, 0);
    check("R11 write one keeps packet", sw_rdata[0], 1);
    sw_write(8'h00);
    check("R11 write zero releases", sw_rdata[0], 0);

    // R3 stall
    @(negedge clk); eng_stall = 1'b1;
    @(negedge clk); eng_stall = 1'b0;
    check("R3 stall bit", sw_rdata[6], 1);
    check("R12 irq on stall", irq, 1);
    sw_write(8'h40);
    check("R3 write one keeps", sw_rdata[6], 1);
    sw_write(8'h00);
    check("R3 write zero clears", sw_rdata[6], 0);

    // R9 error bits
    @(negedge clk); eng_nak_to = 1'b1; eng_err = 1'b1;
    @(negedge clk); eng_nak_to = 1'b0; eng_err = 1'b0;
    check("R9 error bits set", sw_rdata[3:2], 3);
    sw_write(8'h08);
    check("R9 clear bit2 only", sw_rdata[3:2], 2);
    sw_write(8'h00);
    check("R9 clear bit3", sw_rdata[3:2], 0);

    // R6: flush while empty ignored
    sw_write(8'h10);
    check("R6 idle flush", sw_rdata, 8'h00);

    // R5 R6 R7 R8 R13 sweep: k offered, f flushes
    for (int k = 0; k <= 3; k++) begin
      for (int f = 0; f <= 3; f++) begin
        int held, rem;
        sw_write(8'h00); sw_write(8'h00); sw_write(8'h80);
        for (int i = 0; i < k; i++) offer(LW'(len_of(k, i)));
        held = (k > 2) ? 2 : k;
        check("R5 ready", sw_rdata[0], held > 0);
        check("R5 full", sw_rdata[1], held == 2);
        check("R8 toggle parity", eng_toggle, held % 2);
        if (held > 0) check("R13 head", head_len, len_of(k, 0));
        for (int j = 0; j < f; j++) begin
          sw_write(8'h10);
          if (j == 0) check("R6 flush bit", sw_rdata[4], held > 0);
        end
        @(negedge clk);
        check("R6 flush self-clear", sw_rdata[4], 0);
        rem = (held > f) ? held - f : 0;
        check("R7 ready after flush", sw_rdata[0], rem > 0);
        check("R7 full after flush", sw_rdata[1], rem == 2);
        if (rem > 0) check("R7 R13 head after flush", head_len, len_of(k, f));
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule